// File: doc/BRIEF.md
# SPI Controller with Single-Wire Bidirectional Mode

This block is a byte-wide SPI engine that runs as either the clock-generating master or a selected slave. Software configures it through three byte-wide registers on a simple synchronous write port with a combinational read port. A control register selects between the usual two-wire data arrangement and a single shared data pin whose output driver is gated by a software bit. A stop-in-wait bit lets the serial clock freeze while the chip's wait request is asserted. An optional mode-fault check lets a master give up the bus when another device pulls slave-select low.

Transfers are eight bits, MSB first, in SPI mode 0: the clock idles low, data is sampled on the rising edge and changes after the falling edge. The master's clock half-period is a fixed number of system clocks. Slave inputs pass through a synchronizer before use. Changing the pin arrangement while a master transfer is running drops that transfer at once and returns the engine to idle.

Top module: `spi_bidir`

## Requirements
- R1: Address 0 is the control register. Bit 4 = mode-fault enable, bit 3 = shared-pin output enable, bit 1 = stop-in-wait, bit 0 = pin-control (1 = single shared pin). Bits 7, 6, 5 and 2 always read 0 and ignore writes. All bits reset to 0. It can be read or written at any time.
- R2: Address 1 is mode/status. Bit 0 = master select (read/write, reset 0). Bit 1 = mode-fault flag (read-only, cleared by any write to address 1). Bit 2 = done flag. Bit 3 = busy. Upper bits read 0.
- R3: In master mode, a write to address 2 while idle starts an 8-bit MSB-first mode-0 transfer of the written byte. The transfer has 8 clock pulses, each half-period DIV_HALF system clocks, so busy lasts exactly 16*DIV_HALF cycles. Done then sets and the received byte reads back at address 2. Any write to address 2 clears done.
- R4: With pin-control 0, a master drives mosi_o with mosi_oe high, samples miso_i, and keeps miso_oe low.
- R5: With pin-control 1, a master uses only the MOSI pin: mosi_oe equals the output-enable bit, and received data is taken from mosi_i. miso_oe stays low.
- R6: In slave mode, slave-select low selects the block, which samples data on rising sck_in and presents its byte MSB first. With pin-control 0 it reads MOSI and drives MISO. With pin-control 1 both directions use the MISO pin. miso_oe is high only while selected, and with pin-control 1 only if the output-enable bit is also 1.
- R7: In master mode, a control write that changes pin-control aborts a running transfer: busy clears, sck_o returns low and done is not set. With pin-control 1, a change of the output-enable bit does the same. Changes to other control bits do not disturb a transfer.
- R8: A master with mode-fault enable 0 ignores slave-select. With mode-fault enable 1, slave-select low clears master select, sets the fault flag and aborts any transfer.
- R9: With stop-in-wait 1, wait_req holds the serial clock and shift state frozen, and the transfer resumes intact on release. With stop-in-wait 0, wait_req has no effect on timing.
- R10: sck_oe is high exactly when master select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| wait_req | input | 1 | Chip wait-mode request |
| sck_in | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_i | input | 1 | Slave-select input, active low |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO pin output enable |

## Verification
Two functions can act in the same cycle: the wait-mode clock halt and the configuration abort. The bench provokes this by freezing a master transfer mid-byte with stop-in-wait set, then writing a pin-control change while the clock is held. The abort must still take effect during the halt: busy drops at once, and after wait is released no further clock edges appear and done stays clear. The same idea is applied to a mode fault that arrives during a running transfer.

// File: rtl/spi_bidir_pkg.sv
package spi_bidir_pkg;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_MODE = 2'd1;
   localparam logic [1:0] A_DATA = 2'd2;

   localparam int B_MODFEN = 4;
   localparam int B_OE     = 3;
   localparam int B_STOP   = 1;
   localparam int B_PC     = 0;

   typedef struct packed {
      logic modfen;
      logic oe;
      logic stop;
      logic pc;
   } ctrl_t;

endpackage

// File: rtl/spi_bidir_sync.sv
module spi_bidir_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_bidir_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[0] <= INIT;
               else        st[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st[i] <= INIT;
               else        st[i] <= st[i-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];

endmodule

// File: rtl/spi_bidir_regs.sv
module spi_bidir_regs
   import spi_bidir_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   input  logic       ss_low,
   output ctrl_t      ctl,
   output logic       master,
   output logic       fault,
   output logic       abort
);

   ctrl_t nxt;
   logic  ctl_wr, mode_wr, fault_evt, cfg_chg, mst_chg;

   always_comb begin
      nxt.modfen = wdata[B_MODFEN];
      nxt.oe     = wdata[B_OE];
      nxt.stop   = wdata[B_STOP];
      nxt.pc     = wdata[B_PC];
   end

   assign ctl_wr    = wr && (addr == A_CTRL);
   assign mode_wr   = wr && (addr == A_MODE);
   assign fault_evt = master && ctl.modfen && ss_low;
   // pin arrangement change, or driver change while the shared pin is in use
   assign cfg_chg   = ctl_wr && ((nxt.pc != ctl.pc) || (ctl.pc && (nxt.oe != ctl.oe)));
   assign mst_chg   = mode_wr && (wdata[0] != master);
   assign abort     = fault_evt || (master && (cfg_chg || mst_chg));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         master <= 1'b0;
         fault  <= 1'b0;
      end else begin
         if (ctl_wr) ctl <= nxt;
         if (fault_evt)    master <= 1'b0;
         else if (mode_wr) master <= wdata[0];
         if (fault_evt)    fault <= 1'b1;
         else if (mode_wr) fault <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_bidir_engine.sv
module spi_bidir_engine #(
   parameter int DIV_HALF = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       master,
   input  logic       run_en,
   input  logic       abort,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   input  logic       m_din,
   input  logic       s_sck,
   input  logic       s_ss_n,
   input  logic       s_din,
   output logic       sck_r,
   output logic       tx_bit,
   output logic       busy_o,
   output logic       m_busy,
   output logic       done,
   output logic [7:0] rx
);

   localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("spi_bidir_engine: DIV_HALF must be at least 1");
      end
   endgenerate

   logic [7:0]    sh;
   logic [2:0]    cnt;
   logic [DW-1:0] div;
   logic          samp, sck_prev;
   logic          m_tick, s_rise, s_take, m_fin, s_fin;

   assign m_tick = master && m_busy && run_en && (div == DIV_LAST);
   assign s_rise = s_sck && !sck_prev;
   assign s_take = !master && !s_ss_n && run_en && s_rise;
   assign m_fin  = m_tick && sck_r && (cnt == 3'd7) && !abort;
   assign s_fin  = s_take && (cnt == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cnt      <= '0;
         div      <= '0;
         samp     <= 1'b0;
         sck_r    <= 1'b0;
         m_busy   <= 1'b0;
         rx       <= '0;
         done     <= 1'b0;
         sck_prev <= 1'b0;
      end else begin
         sck_prev <= s_sck;
         if (m_fin || s_fin) done <= 1'b1;
         else if (data_wr)   done <= 1'b0;

         if (abort) begin
            m_busy <= 1'b0;
            sck_r  <= 1'b0;
            div    <= '0;
            cnt    <= '0;
         end else if (master) begin
            if (data_wr && !m_busy) begin
               sh     <= wdata;
               m_busy <= 1'b1;
               sck_r  <= 1'b0;
               div    <= '0;
               cnt    <= '0;
            end else if (m_busy && run_en) begin
               if (div == DIV_LAST) begin
                  div <= '0;
                  if (!sck_r) begin
                     sck_r <= 1'b1;
                     samp  <= m_din;
                  end else begin
                     sck_r <= 1'b0;
                     sh    <= {sh[6:0], samp};
                     cnt   <= cnt + 3'd1;
                     if (cnt == 3'd7) begin
                        m_busy <= 1'b0;
                        rx     <= {sh[6:0], samp};
                     end
                  end
               end else begin
                  div <= div + DW'(1);
               end
            end
         end else begin
            m_busy <= 1'b0;
            sck_r  <= 1'b0;
            if (s_ss_n) begin
               cnt <= '0;
               if (data_wr) sh <= wdata;
            end else if (s_take) begin
               // slave shifts after the synchronized rising edge; the next
               // bit is settled well before the master's following rise
               sh  <= {sh[6:0], s_din};
               cnt <= cnt + 3'd1;
               if (cnt == 3'd7) rx <= {sh[6:0], s_din};
            end else if (data_wr && (cnt == 3'd0)) begin
               sh <= wdata;
            end
         end
      end
   end

   assign tx_bit = sh[7];
   assign busy_o = m_busy || (!master && (cnt != 3'd0));

endmodule

// File: rtl/spi_bidir_pins.sv
module spi_bidir_pins (
   input  logic master,
   input  logic pc,
   input  logic oe,
   input  logic sel,
   input  logic tx_bit,
   input  logic sck_r,
   input  logic mosi_i,
   input  logic miso_i,
   input  logic s_mosi,
   input  logic s_miso,
   output logic sck_o,
   output logic sck_oe,
   output logic mosi_o,
   output logic mosi_oe,
   output logic miso_o,
   output logic miso_oe,
   output logic m_din,
   output logic s_din
);

   logic drv_ok;

   assign drv_ok  = pc ? oe : 1'b1;
   assign sck_o   = sck_r;
   assign sck_oe  = master;
   assign mosi_o  = master ? tx_bit : 1'b0;
   assign mosi_oe = master && drv_ok;
   assign miso_o  = master ? 1'b0 : tx_bit;
   assign miso_oe = !master && sel && drv_ok;
   assign m_din   = pc ? mosi_i : miso_i;
   assign s_din   = pc ? s_miso : s_mosi;

endmodule

// File: rtl/spi_bidir.sv
module spi_bidir
   import spi_bidir_pkg::*;
#(
   parameter int DIV_HALF    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       wait_req,
   input  logic       sck_in,
   output logic       sck_o,
   output logic       sck_oe,
   input  logic       ss_i,
   input  logic       mosi_i,
   output logic       mosi_o,
   output logic       mosi_oe,
   input  logic       miso_i,
   output logic       miso_o,
   output logic       miso_oe
);

   ctrl_t      ctl;
   logic       mst, fault, abort, run_en, data_wr;
   logic       c_modfen, c_oe, c_stop, c_pc;
   logic       sck_r, tx_bit, busy_any, eng_busy, done;
   logic       m_din, s_din;
   logic [7:0] rx;
   logic [3:0] syn_q;
   logic       s_sck, ss_s, s_mosi, s_miso;

   spi_bidir_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({miso_i, ss_i, mosi_i, sck_in}),
      .q(syn_q)
   );
   assign {s_miso, ss_s, s_mosi, s_sck} = syn_q;

   spi_bidir_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .ss_low(!ss_s), .ctl(ctl), .master(mst), .fault(fault), .abort(abort)
   );

   assign c_modfen = ctl.modfen;
   assign c_oe     = ctl.oe;
   assign c_stop   = ctl.stop;
   assign c_pc     = ctl.pc;
   assign run_en   = !(c_stop && wait_req);
   assign data_wr  = reg_wr && (reg_addr == A_DATA);

   spi_bidir_engine #(.DIV_HALF(DIV_HALF)) u_eng (
      .clk(clk), .rst_n(rst_n), .master(mst), .run_en(run_en), .abort(abort),
      .data_wr(data_wr), .wdata(reg_wdata), .m_din(m_din),
      .s_sck(s_sck), .s_ss_n(ss_s), .s_din(s_din),
      .sck_r(sck_r), .tx_bit(tx_bit), .busy_o(busy_any), .m_busy(eng_busy),
      .done(done), .rx(rx)
   );

   spi_bidir_pins u_pins (
      .master(mst), .pc(c_pc), .oe(c_oe), .sel(!ss_s), .tx_bit(tx_bit), .sck_r(sck_r),
      .mosi_i(mosi_i), .miso_i(miso_i), .s_mosi(s_mosi), .s_miso(s_miso),
      .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_o(miso_o), .miso_oe(miso_oe), .m_din(m_din), .s_din(s_din)
   );

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = {3'b000, c_modfen, c_oe, 1'b0, c_stop, c_pc};
         A_MODE:  reg_rdata = {4'b0000, busy_any, done, fault, mst};
         A_DATA:  reg_rdata = rx;
         default: reg_rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/spi_bidir_chk.sv
module spi_bidir_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_rdata,
   input logic       mst,
   input logic       c_modfen,
   input logic       ss_s,
   input logic       abort,
   input logic       eng_busy,
   input logic       run_en,
   input logic       done,
   input logic       sck_o
);

   assert_resv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> ((reg_rdata & 8'hE4) == 8'h00));

   assert_done_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && mst) |-> $past(eng_busy));

   assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!eng_busy && !sck_o));

   assert_fault_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mst && c_modfen && !ss_s) |=> !mst);

   assert_ss_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mst && !c_modfen && !(reg_wr && reg_addr == 2'd1)) |=> mst);

   assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && !run_en && !abort) |=> $stable(sck_o));

endmodule

bind spi_bidir spi_bidir_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_rdata(reg_rdata), .mst(mst), .c_modfen(c_modfen), .ss_s(ss_s),
   .abort(abort), .eng_busy(eng_busy), .run_en(run_en), .done(done), .sck_o(sck_o)
);

// File: tb/sim_spi_bidir.sv
`timescale 1ns/1ps
module sim_spi_bidir;

   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       wait_req = 1'b0;
   logic       sck_in = 1'b0;
   logic       sck_o, sck_oe;
   logic       ss_i = 1'b1;
   logic       mosi_i, mosi_o, mosi_oe;
   logic       miso_i, miso_o, miso_oe;

   logic       slv_test = 1'b0;
   logic       bm_mosi = 1'b0;
   logic [7:0] ext_byte = 8'h00;
   logic       ext_ld = 1'b0;
   logic [7:0] ext_sh = 8'h00;
   logic [7:0] ext_cap = 8'h00;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   spi_bidir #(.DIV_HALF(DIV), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_req(wait_req),
      .sck_in(sck_in), .sck_o(sck_o), .sck_oe(sck_oe), .ss_i(ss_i),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
      .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
   );

   // external device model: shifts its byte out after each master falling edge
   always @(negedge sck_o or posedge ext_ld) begin
      if (ext_ld) ext_sh <= ext_byte;
      else        ext_sh <= {ext_sh[6:0], 1'b0};
   end
   always @(posedge sck_o) ext_cap <= {ext_cap[6:0], mosi_o};

   assign mosi_i = slv_test ? bm_mosi : (mosi_oe ? mosi_o : ext_sh[7]);
   assign miso_i = miso_oe ? miso_o : ext_sh[7];

   function automatic logic [7:0] exp_ctrl(input logic [7:0] w);
      return w & 8'h1B;
   endfunction

   function automatic logic [7:0] exp_mrx(input logic pc, input logic oe,
                                          input logic [7:0] tx, input logic [7:0] ext);
      return (pc && oe) ? tx : ext;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic load_ext(input logic [7:0] b);
      ext_byte = b;
      ext_ld = 1'b1;
      #0.1;
      ext_ld = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int n = 0; n < 4000; n++) begin
         rd(2'd1, s);
         if (!s[3]) break;
      end
   endtask

   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] ext,
                              output logic [7:0] got);
      load_ext(ext);
      wr(2'd2, tx);
      wait_idle();
      rd(2'd2, got);
   endtask

   task automatic slave_byte(input logic [7:0] mo, output logic [7:0] seen);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         bm_mosi = mo[i];
         repeat (8) @(negedge clk);
         seen[i] = miso_o;
         sck_in = 1'b1;
         repeat (8) @(negedge clk);
         sck_in = 1'b0;
         repeat (8) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [7:0] r, tx, ext, seen;
      logic       pc, oe, s0;
      int         n;
      void'($urandom(32'd20240611));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(2'd0, r); chk("R1 ctrl reset", r, 8'h00);
      rd(2'd1, r); chk("R2 mode reset", r, 8'h00);
      rd(2'd2, r); chk("R3 data reset", r, 8'h00);
      chk("R10 sck_oe in reset", sck_oe, 1'b0);
      chk("R6 miso_oe unselected", miso_oe, 1'b0);

      // reserved bits
      wr(2'd0, 8'hFF); rd(2'd0, r); chk("R1 reserved bits", r, exp_ctrl(8'hFF));
      wr(2'd0, 8'hE4); rd(2'd0, r); chk("R1 reserved only", r, exp_ctrl(8'hE4));
      wr(2'd0, 8'h00);

      // master enable
      wr(2'd1, 8'h01); rd(2'd1, r); chk("R2 master bit", r, 8'h01);
      chk("R10 sck_oe master", sck_oe, 1'b1);
      chk("R4 mosi_oe normal", mosi_oe, 1'b1);
      chk("R4 miso_oe normal", miso_oe, 1'b0);

      // directed master transfer
      master_xfer(8'hA5, 8'h3C, r);
      chk("R3 rx byte", r, 8'h3C);
      chk("R4 sent byte", ext_cap, 8'hA5);
      rd(2'd1, r); chk("R3 done set", r[2], 1'b1);
      load_ext(8'h81);
      wr(2'd2, 8'h7E);
      rd(2'd1, r); chk("R3 done cleared by data write", r[3:2], 2'b10);
      wait_idle();
      rd(2'd2, r); chk("R3 rx second", r, 8'h81);
      chk("R4 sent second", ext_cap, 8'h7E);

      // random master transfers over both pin arrangements
      for (int k = 0; k < 14; k++) begin
         pc  = 1'($urandom % 2);
         oe  = 1'($urandom % 2);
         tx  = 8'($urandom);
         ext = 8'($urandom);
         wr(2'd0, {4'b0000, oe, 2'b00, pc});
         chk(pc ? "R5 mosi_oe shared" : "R4 mosi_oe normal", mosi_oe, pc ? oe : 1'b1);
         chk("R5 miso_oe master", miso_oe, 1'b0);
         master_xfer(tx, ext, r);
         chk(pc ? "R5 rx shared pin" : "R4 rx normal", r, exp_mrx(pc, oe, tx, ext));
         if (!pc) chk("R4 random sent", ext_cap, tx);
      end

      // stop-in-wait off: wait has no timing effect
      wr(2'd0, 8'h00);
      wait_req = 1'b1;
      load_ext(8'h5A);
      wr(2'd2, 8'hC3);
      n = 0;
      for (int c = 1; c < 1000; c++) begin
         rd(2'd1, r);
         if (!r[3]) begin n = c; break; end
      end
      chk("R9 wait ignored duration", n, 16 * DIV);
      rd(2'd2, r); chk("R9 wait ignored rx", r, 8'h5A);
      wait_req = 1'b0;

      // stop-in-wait on: freeze and resume
      wr(2'd0, 8'h02);
      load_ext(8'h96);
      wr(2'd2, 8'h69);
      repeat (22) @(negedge clk);
      wait_req = 1'b1;
      @(negedge clk);
      s0 = sck_o;
      repeat (40) @(negedge clk);
      chk("R9 sck frozen", sck_o, s0);
      rd(2'd1, r); chk("R9 busy while frozen", r[3], 1'b1);
      wait_req = 1'b0;
      wait_idle();
      rd(2'd2, r); chk("R9 resumed rx", r, 8'h96);
      chk("R9 resumed sent", ext_cap, 8'h69);

      // halt and abort in the same window
      load_ext(8'hF0);
      wr(2'd2, 8'h0F);
      repeat (18) @(negedge clk);
      wait_req = 1'b1;
      repeat (5) @(negedge clk);
      wr(2'd0, 8'h03);
      rd(2'd1, r); chk("R7 abort while halted", r[3:2], 2'b00);
      wait_req = 1'b0;
      repeat (100) @(negedge clk);
      rd(2'd1, r); chk("R7 no done after abort", r[2], 1'b0);
      chk("R7 sck low after abort", sck_o, 1'b0);

      // output-enable change aborts in shared-pin mode
      wr(2'd0, 8'h09);
      wr(2'd2, 8'h33);
      repeat (10) @(negedge clk);
      wr(2'd0, 8'h01);
      rd(2'd1, r); chk("R7 oe change aborts", r[3], 1'b0);

      // pin-control change aborts in normal mode
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h44);
      repeat (10) @(negedge clk);
      wr(2'd0, 8'h01);
      rd(2'd1, r); chk("R7 pc change aborts", r[3], 1'b0);

      // stop bit change does not abort
      wr(2'd0, 8'h00);
      load_ext(8'hB7);
      wr(2'd2, 8'h12);
      repeat (10) @(negedge clk);
      wr(2'd0, 8'h02);
      wait_idle();
      rd(2'd2, r); chk("R7 unrelated write keeps transfer", r, 8'hB7);

      // mode fault
      wr(2'd0, 8'h00);
      ss_i = 1'b0;
      repeat (10) @(negedge clk);
      rd(2'd1, r); chk("R8 ss ignored without enable", r[1:0], 2'b01);
      wr(2'd0, 8'h10);
      repeat (6) @(negedge clk);
      rd(2'd1, r); chk("R8 fault clears master", r[1:0], 2'b10);
      chk("R10 sck_oe after fault", sck_oe, 1'b0);
      ss_i = 1'b1;
      repeat (4) @(negedge clk);
      wr(2'd1, 8'h01);
      rd(2'd1, r); chk("R2 fault cleared by mode write", r[1:0], 2'b01);
      wr(2'd2, 8'h55);
      repeat (10) @(negedge clk);
      ss_i = 1'b0;
      repeat (6) @(negedge clk);
      rd(2'd1, r); chk("R8 fault mid transfer", r[3:0], 4'b0010);
      ss_i = 1'b1;
      wr(2'd0, 8'h00);
      repeat (4) @(negedge clk);

      // slave, normal pins
      slv_test = 1'b1;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'hD2);
      ss_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 miso_oe selected", miso_oe, 1'b1);
      chk("R6 mosi_oe slave", mosi_oe, 1'b0);
      tx = 8'($urandom);
      slave_byte(tx, seen);
      ss_i = 1'b1;
      repeat (6) @(negedge clk);
      rd(2'd2, r); chk("R6 slave rx", r, tx);
      chk("R6 slave tx", seen, 8'hD2);
      rd(2'd1, r); chk("R6 slave done", r[2], 1'b1);
      chk("R6 miso_oe released", miso_oe, 1'b0);

      // slave, shared MISO pin
      wr(2'd0, 8'h01);
      ss_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 shared pin driver off", miso_oe, 1'b0);
      wr(2'd0, 8'h09);
      chk("R6 shared pin driver on", miso_oe, 1'b1);
      wr(2'd2, 8'h6B);
      slave_byte(8'($urandom), seen);
      ss_i = 1'b1;
      repeat (6) @(negedge clk);
      rd(2'd2, r); chk("R6 shared pin loop rx", r, 8'h6B);
      chk("R6 shared pin driven", seen, 8'h6B);

      summary();
   end

endmodule